// File: doc/BRIEF.md
# Block-Transfer Channel Sequencer

This block runs one channel of a block-transfer engine. It moves 16-bit half-words between a peripheral and memory without the processor. First a 16-bit command word either links a device to the channel or gives channel control orders such as clear, disconnect, and interrupt enables. After a fixed settling time the link is ready. A 32-bit block word then gives the start address, a word count and four option bits. The sequencer steps once for each device strobe. On each step it either transfers a half-word or skips it, and it advances through the left and right halves of each memory word.

A block ends when the count runs out, when the device raises its end line, or on whichever of the two comes first. At the end the link can be dropped, and a completion pulse is always raised. If the end line stopped the block early, the remaining count stays visible on the ports. Reads from memory are combinational: the device data for a memory-to-device step comes from the memory read port in the same cycle.

Top module: `blk_chan`

## Requirements
- R1: A command whose bit 0 is set, whose bits 3..1 equal CHAN_ID and whose bits 7..4 are nonzero is a link order. If the channel is neither settling nor running a block, `busy` is high for CONN_CYC cycles from the next edge and `connected` is low. Then `connected` rises and `busy` falls. After the link order, `cfg_dev` shows bits 7..4, `cfg_binary` shows bit 9 and `cfg_pack` shows bits 15..13.
- R2: A link order is ignored if it names another channel, has bit 0 clear, or arrives while the channel is settling or running.
- R3: A block word is taken only when the channel is connected, not busy and not running. Any other block word leaves the state unchanged, and `ctl_reject` pulses high for one cycle after it.
- R4: Link bit 12 set means device to memory. In transfer mode each step asserts `mem_we` with `mem_wdata` equal to `dev_in_data`. `mem_wexec` follows `dev_in_exec` only when link bit 8 is set.
- R5: Link bit 12 clear means memory to device. In transfer mode each step asserts `mem_re` and `dev_out_valid`, and `dev_out_data` equals `mem_rdata` in the same cycle. `dev_out_exec` follows `mem_rexec` only when link bit 8 is set.
- R6: Block bit 16 clear selects skip mode. Steps advance the address, half and count, but there is no memory access and no device output.
- R7: `mem_half` (0 = left) starts at left when link bit 10 is set and at right when it is clear. With link bit 11 set, the half toggles on every step and `mem_addr` (loaded from the block word's low AW bits) advances after every second step. With bit 11 clear, the half is fixed and the address advances on every step.
- R8: The count is held in block bits 31..32-CW and drops by one for each completed word. With block bit 19 set, the block ends at the edge where the count reaches zero. A zero count loaded with bit 19 set ends the block at the next edge, with no step.
- R9: With block bit 18 set, `dev_end` ends the block at that edge, after any step in the same cycle. `remain_cnt` then keeps the count that was left. If both bit 18 and bit 19 are set, whichever condition occurs first ends the block.
- R10: `irq_done` is high for exactly the one cycle after a block ends by count or by signal.
- R11: With block bit 17 set, `connected` falls at the same edge as `active`. With bit 17 clear, the channel stays connected.
- R12: A command for this channel with bits 7..4 zero is a control order, and its bits act together. Bit 0 aborts the block with no `irq_done` and clears busy, the link and both enables. Bit 15 aborts and unlinks. Bits 11/12 clear/set the signal enable and bits 13/14 clear/set the ready enable; when both bits of a pair are given, the set wins. `irq_sig` equals the signal enable AND `dev_end`. `irq_rdy` equals the ready enable AND connected, not busy, not active.
- R13: After reset, every output that carries state is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Link or control order |
| ctl_valid | input | 1 | Block word strobe |
| ctl_word | input | 32 | Address, options, count |
| dev_stb | input | 1 | Device requests one step |
| dev_end | input | 1 | Device end signal |
| dev_in_data | input | DW | Half-word from device |
| dev_in_exec | input | 1 | Exec bit from device |
| dev_out_valid | output | 1 | Half-word to device is valid |
| dev_out_data | output | DW | Half-word to device |
| dev_out_exec | output | 1 | Exec bit to device |
| mem_we | output | 1 | Memory half-word write |
| mem_re | output | 1 | Memory half-word read |
| mem_addr | output | AW | Memory word address |
| mem_half | output | 1 | 0 left, 1 right |
| mem_wdata | output | DW | Write data |
| mem_wexec | output | 1 | Write exec bit |
| mem_rdata | input | DW | Read data, same cycle |
| mem_rexec | input | 1 | Read exec bit |
| busy | output | 1 | Link settling |
| connected | output | 1 | Link established |
| active | output | 1 | Block running |
| cfg_dev | output | 4 | Linked device code |
| cfg_binary | output | 1 | Binary (1) or BCD (0) mode |
| cfg_pack | output | 3 | Byte packing code |
| remain_cnt | output | CW | Count left |
| irq_done | output | 1 | Block completion pulse |
| irq_sig | output | 1 | Signal interrupt |
| irq_rdy | output | 1 | Ready interrupt |
| ctl_reject | output | 1 | Block word refused |

## Verification
A wrong half or phase bit shows on `mem_half` at the very next strobe, and on `mem_addr` within two steps in alternating mode. A count that is off by one moves the edge at which `active` falls and `irq_done` pulses, and it leaves a wrong value on `remain_cnt` that stays visible until the next block. A stale link or busy state shows up the same cycle on `irq_rdy`, `connected` or `ctl_reject`. The reference model is therefore compared on every cycle, so a fault is caught at its first cycle rather than only at the end of a block.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef struct packed {
    logic [3:0] dev;
    logic       exec_en;
    logic       binary;
    logic       start_left;
    logic       alternate;
    logic       dir_in;
    logic [2:0] pack;
  } link_cfg_t;

  typedef struct packed {
    logic xfer;
    logic disc_end;
    logic stop_sig;
    logic stop_cnt;
  } blk_opt_t;

  localparam int OPT_XFER = 16;
  localparam int OPT_DISC = 17;
  localparam int OPT_SSIG = 18;
  localparam int OPT_SCNT = 19;

  function automatic link_cfg_t decode_link(input logic [15:0] w);
    link_cfg_t c;
    c.dev        = w[7:4];
    c.exec_en    = w[8];
    c.binary     = w[9];
    c.start_left = w[10];
    c.alternate  = w[11];
    c.dir_in     = w[12];
    c.pack       = w[15:13];
    return c;
  endfunction
endpackage

// File: rtl/chan_cmd.sv
module chan_cmd import chan_pkg::*; #(
  parameter int CHAN_ID  = 3,
  parameter int CONN_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic        blk_active,
  input  logic        blk_end,
  input  logic        disc_end,
  output logic        busy,
  output logic        connected,
  output link_cfg_t   cfg,
  output logic        sig_en,
  output logic        rdy_en,
  output logic        abort
);
  localparam int BW = $clog2(CONN_CYC + 1);

  logic            busy_q, busy_d, conn_q, conn_d, sig_q, sig_d, rdy_q, rdy_d;
  logic [BW-1:0]   bcnt_q, bcnt_d;
  link_cfg_t       cfg_q, cfg_d;
  logic            hit, is_ctrl, is_link;

  assign hit     = cmd_valid && (cmd_word[3:1] == 3'(CHAN_ID));
  assign is_ctrl = hit && (cmd_word[7:4] == 4'd0);
  assign is_link = hit && (cmd_word[7:4] != 4'd0) && cmd_word[0] && !busy_q && !blk_active;
  assign abort   = is_ctrl && (cmd_word[0] || cmd_word[15]);

  always_comb begin
    busy_d = busy_q;
    bcnt_d = bcnt_q;
    conn_d = conn_q;
    cfg_d  = cfg_q;
    sig_d  = sig_q;
    rdy_d  = rdy_q;
    if (busy_q) begin
      if (bcnt_q == BW'(1)) begin
        busy_d = 1'b0;
        conn_d = 1'b1;
      end else begin
        bcnt_d = bcnt_q - BW'(1);
      end
    end
    if (blk_end && disc_end) conn_d = 1'b0;
    if (is_link) begin
      busy_d = 1'b1;
      bcnt_d = BW'(CONN_CYC);
      conn_d = 1'b0;
      cfg_d  = decode_link(cmd_word);
    end
    if (is_ctrl) begin
      if (cmd_word[0]) begin
        busy_d = 1'b0;
        conn_d = 1'b0;
        sig_d  = 1'b0;
        rdy_d  = 1'b0;
      end
      if (cmd_word[15]) begin
        busy_d = 1'b0;
        conn_d = 1'b0;
      end
      if (cmd_word[11]) sig_d = 1'b0;
      if (cmd_word[12]) sig_d = 1'b1;
      if (cmd_word[13]) rdy_d = 1'b0;
      if (cmd_word[14]) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      conn_q <= 1'b0;
      cfg_q  <= '0;
      sig_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bcnt_q <= bcnt_d;
      conn_q <= conn_d;
      cfg_q  <= cfg_d;
      sig_q  <= sig_d;
      rdy_q  <= rdy_d;
    end
  end

  assign busy      = busy_q;
  assign connected = conn_q;
  assign cfg       = cfg_q;
  assign sig_en    = sig_q;
  assign rdy_en    = rdy_q;
endmodule

// File: rtl/chan_seq.sv
module chan_seq import chan_pkg::*; #(
  parameter int AW = 8,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_valid,
  input  logic [31:0]   ctl_word,
  input  logic          link_ready,
  input  logic          start_left,
  input  logic          alternate,
  input  logic          dev_stb,
  input  logic          dev_end,
  input  logic          abort,
  output logic          active,
  output logic          xfer_step,
  output logic          blk_end,
  output logic          disc_end,
  output logic [AW-1:0] addr,
  output logic          half,
  output logic [CW-1:0] remain,
  output logic          irq_done,
  output logic          ctl_reject
);
  localparam int CNT_LSB = 32 - CW;

  logic          act_q, act_d, half_q, half_d, ph_q, ph_d, done_q, rej_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_after;
  blk_opt_t      opt_q, opt_d;
  logic          hold, step, word_done, accept;

  assign hold      = opt_q.stop_cnt && (cnt_q == '0);
  assign step      = act_q && dev_stb && !hold;
  assign word_done = step && (!alternate || ph_q);
  assign cnt_after = word_done ? cnt_q - CW'(1) : cnt_q;
  assign blk_end   = act_q && !abort &&
                     ((opt_q.stop_cnt && cnt_after == '0) || (opt_q.stop_sig && dev_end));
  assign accept    = ctl_valid && link_ready && !act_q;

  always_comb begin
    act_d  = act_q;
    addr_d = word_done ? addr_q + AW'(1) : addr_q;
    cnt_d  = cnt_after;
    half_d = (step && alternate) ? !half_q : half_q;
    ph_d   = (step && alternate) ? !ph_q : ph_q;
    opt_d  = opt_q;
    if (accept) begin
      act_d  = 1'b1;
      addr_d = ctl_word[AW-1:0];
      cnt_d  = ctl_word[CNT_LSB +: CW];
      half_d = !start_left;
      ph_d   = 1'b0;
      opt_d  = '{xfer: ctl_word[OPT_XFER], disc_end: ctl_word[OPT_DISC],
                 stop_sig: ctl_word[OPT_SSIG], stop_cnt: ctl_word[OPT_SCNT]};
    end
    if (abort) act_d = 1'b0;
    else if (blk_end) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      ph_q   <= 1'b0;
      opt_q  <= '0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      ph_q   <= ph_d;
      opt_q  <= opt_d;
      done_q <= blk_end;
      rej_q  <= ctl_valid && !accept;
    end
  end

  assign active     = act_q;
  assign xfer_step  = step && opt_q.xfer;
  assign disc_end   = opt_q.disc_end;
  assign addr       = addr_q;
  assign half       = half_q;
  assign remain     = cnt_q;
  assign irq_done   = done_q;
  assign ctl_reject = rej_q;
endmodule

// File: rtl/chan_port.sv
module chan_port #(
  parameter int DW = 16
) (
  input  logic          xfer_step,
  input  logic          dir_in,
  input  logic          exec_en,
  input  logic [DW-1:0] dev_in_data,
  input  logic          dev_in_exec,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rexec,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wexec,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  output logic          dev_out_exec
);
  assign mem_we        = xfer_step && dir_in;
  assign mem_re        = xfer_step && !dir_in;
  assign mem_wdata     = mem_we ? dev_in_data : '0;
  assign mem_wexec     = mem_we && exec_en && dev_in_exec;
  assign dev_out_valid = mem_re;
  assign dev_out_data  = mem_re ? mem_rdata : '0;
  assign dev_out_exec  = mem_re && exec_en && mem_rexec;
endmodule

// File: rtl/blk_chan.sv
module blk_chan import chan_pkg::*; #(
  parameter int CHAN_ID  = 3,
  parameter int AW       = 8,
  parameter int CW       = 12,
  parameter int DW       = 16,
  parameter int CONN_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [15:0]   cmd_word,
  input  logic          ctl_valid,
  input  logic [31:0]   ctl_word,
  input  logic          dev_stb,
  input  logic          dev_end,
  input  logic [DW-1:0] dev_in_data,
  input  logic          dev_in_exec,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  output logic          dev_out_exec,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          mem_half,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wexec,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rexec,
  output logic          busy,
  output logic          connected,
  output logic          active,
  output logic [3:0]    cfg_dev,
  output logic          cfg_binary,
  output logic [2:0]    cfg_pack,
  output logic [CW-1:0] remain_cnt,
  output logic          irq_done,
  output logic          irq_sig,
  output logic          irq_rdy,
  output logic          ctl_reject
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  link_cfg_t cfg;
  logic      sig_en, rdy_en, abort, blk_end, disc_end, xfer_step;

  chan_cmd #(.CHAN_ID(CHAN_ID), .CONN_CYC(CONN_CYC)) u_cmd (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .blk_active(active), .blk_end(blk_end), .disc_end(disc_end),
    .busy(busy), .connected(connected), .cfg(cfg), .sig_en(sig_en),
    .rdy_en(rdy_en), .abort(abort)
  );

  chan_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
    .link_ready(connected && !busy), .start_left(cfg.start_left),
    .alternate(cfg.alternate), .dev_stb(dev_stb), .dev_end(dev_end),
    .abort(abort), .active(active), .xfer_step(xfer_step), .blk_end(blk_end),
    .disc_end(disc_end), .addr(mem_addr), .half(mem_half), .remain(remain_cnt),
    .irq_done(irq_done), .ctl_reject(ctl_reject)
  );

  chan_port #(.DW(DW)) u_port (
    .xfer_step(xfer_step), .dir_in(cfg.dir_in), .exec_en(cfg.exec_en),
    .dev_in_data(dev_in_data), .dev_in_exec(dev_in_exec),
    .mem_rdata(mem_rdata), .mem_rexec(mem_rexec), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_wexec(mem_wexec),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_exec(dev_out_exec)
  );

  assign cfg_dev    = cfg.dev;
  assign cfg_binary = cfg.binary;
  assign cfg_pack   = cfg.pack;
  assign irq_sig    = sig_en && dev_end;
  assign irq_rdy    = rdy_en && connected && !busy && !active;
endmodule

// File: rtl/blk_chan_chk.sv
module blk_chan_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          connected,
  input logic          active,
  input logic          irq_done,
  input logic          ctl_reject,
  input logic          mem_we,
  input logic          mem_re,
  input logic          dev_out_valid,
  input logic [CW-1:0] remain_cnt
);
  // R1
  busy_unlinked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !connected);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  // R10
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (!active && $past(active)));
  // R3
  reject_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reject |-> !$rose(active));
  // R5
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R6
  access_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || dev_out_valid) |-> active);
  // R9
  remain_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (active || $stable(remain_cnt)));
endmodule

bind blk_chan blk_chan_chk #(.CW(CW)) u_chk (.*);

// File: tb/blk_chan_test.sv
module blk_chan_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, cmd_valid, ctl_valid, dev_stb, dev_end, dev_in_exec, mem_rexec;
  logic [15:0] cmd_word, dev_in_data, mem_rdata;
  logic [31:0] ctl_word;
  logic        dev_out_valid, dev_out_exec, mem_we, mem_re, mem_half, mem_wexec;
  logic [15:0] dev_out_data, mem_wdata;
  logic [7:0]  mem_addr;
  logic        busy, connected, active, cfg_binary, irq_done, irq_sig, irq_rdy, ctl_reject;
  logic [3:0]  cfg_dev;
  logic [2:0]  cfg_pack;
  logic [11:0] remain_cnt;

  blk_chan uut (.*);

  logic [15:0] bmem [0:255][0:1];
  logic        bx   [0:255][0:1];
  assign mem_rdata = bmem[mem_addr][mem_half];
  assign mem_rexec = bx[mem_addr][mem_half];
  always @(posedge clk) if (mem_we) begin
    bmem[mem_addr][mem_half] <= mem_wdata;
    bx[mem_addr][mem_half]   <= mem_wexec;
  end

  int total = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  logic m_busy, m_conn, m_act, m_half, m_ph, m_done, m_rej, m_ex, m_bin, m_left, m_alt, m_din;
  logic m_xf, m_disc, m_ssig, m_scnt, m_sen, m_ren;
  logic [3:0] m_dev; logic [2:0] m_pack;
  int m_bcnt, m_addr, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_conn = 0; m_act = 0; m_half = 0; m_ph = 0; m_done = 0; m_rej = 0;
      m_ex = 0; m_bin = 0; m_left = 0; m_alt = 0; m_din = 0; m_xf = 0; m_disc = 0;
      m_ssig = 0; m_scnt = 0; m_sen = 0; m_ren = 0; m_dev = 0; m_pack = 0;
      m_bcnt = 0; m_addr = 0; m_cnt = 0;
    end else begin
      bit hit, ctrl, abort, link, ready, endb, was_act;
      hit   = cmd_valid && cmd_word[3:1] == 3'd3;
      ctrl  = hit && cmd_word[7:4] == 0;
      abort = ctrl && (cmd_word[0] || cmd_word[15]);
      link  = hit && cmd_word[7:4] != 0 && cmd_word[0] && !m_busy && !m_act;
      ready = m_conn && !m_busy;
      was_act = m_act;
      endb = 0;
      if (m_act) begin
        if (dev_stb && !(m_scnt && m_cnt == 0)) begin
          if (m_alt) begin
            if (m_ph) begin m_addr = (m_addr + 1) % 256; m_cnt = (m_cnt - 1) & 12'hFFF; end
            m_ph = !m_ph; m_half = !m_half;
          end else begin
            m_addr = (m_addr + 1) % 256; m_cnt = (m_cnt - 1) & 12'hFFF;
          end
        end
        endb = !abort && ((m_scnt && m_cnt == 0) || (m_ssig && dev_end));
      end
      m_done = endb;
      m_rej = 0;
      if (ctl_valid) begin
        if (ready && !was_act) begin
          m_act = 1; m_addr = ctl_word[7:0]; m_cnt = ctl_word[31:20];
          m_xf = ctl_word[16]; m_disc = ctl_word[17]; m_ssig = ctl_word[18]; m_scnt = ctl_word[19];
          m_half = !m_left; m_ph = 0;
        end else m_rej = 1;
      end
      if (abort) m_act = 0;
      else if (endb) begin m_act = 0; if (m_disc) m_conn = 0; end
      if (m_busy) begin
        if (m_bcnt == 1) begin m_busy = 0; m_conn = 1; end else m_bcnt--;
      end
      if (link) begin
        m_busy = 1; m_bcnt = 4; m_conn = 0;
        m_dev = cmd_word[7:4]; m_ex = cmd_word[8]; m_bin = cmd_word[9]; m_left = cmd_word[10];
        m_alt = cmd_word[11]; m_din = cmd_word[12]; m_pack = cmd_word[15:13];
      end
      if (ctrl) begin
        if (cmd_word[0]) begin m_busy = 0; m_conn = 0; m_sen = 0; m_ren = 0; end
        if (cmd_word[15]) begin m_busy = 0; m_conn = 0; end
        if (cmd_word[11]) m_sen = 0;
        if (cmd_word[12]) m_sen = 1;
        if (cmd_word[13]) m_ren = 0;
        if (cmd_word[14]) m_ren = 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit xs, ewe, ere;
    xs  = m_act && dev_stb && !(m_scnt && m_cnt == 0) && m_xf;
    ewe = xs && m_din;
    ere = xs && !m_din;
    chk("R1 busy", busy, m_busy);
    chk("R11 connected", connected, m_conn);
    chk("R8 active", active, m_act);
    chk("R10 irq_done", irq_done, m_done);
    chk("R9 remain_cnt", remain_cnt, m_cnt);
    chk("R3 ctl_reject", ctl_reject, m_rej);
    chk("R7 mem_addr", mem_addr, m_addr);
    chk("R7 mem_half", mem_half, m_half);
    chk("R4 mem_we", mem_we, ewe);
    chk("R4 mem_wdata", mem_wdata, ewe ? dev_in_data : 16'h0);
    chk("R4 mem_wexec", mem_wexec, ewe && m_ex && dev_in_exec);
    chk("R5 mem_re", mem_re, ere);
    chk("R6 dev_out_valid", dev_out_valid, ere);
    chk("R5 dev_out_data", dev_out_data, ere ? mem_rdata : 16'h0);
    chk("R5 dev_out_exec", dev_out_exec, ere && m_ex && mem_rexec);
    chk("R1 cfg_dev", cfg_dev, m_dev);
    chk("R1 cfg_binary", cfg_binary, m_bin);
    chk("R1 cfg_pack", cfg_pack, m_pack);
    chk("R12 irq_sig", irq_sig, m_sen && dev_end);
    chk("R12 irq_rdy", irq_rdy, m_ren && m_conn && !m_busy && !m_act);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic cmd(input logic [15:0] w);
    cmd_valid = 1; cmd_word = w; tick(); cmd_valid = 0; cmd_word = 0;
  endtask
  task automatic blk(input logic [31:0] w);
    ctl_valid = 1; ctl_word = w; tick(); ctl_valid = 0; ctl_word = 0;
  endtask
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      dev_stb = (i % 3 != 2); dev_in_data = 16'hA000 + 16'(i * 17); dev_in_exec = i[0];
      tick();
    end
    dev_stb = 0;
  endtask
  function automatic logic [15:0] lnk(input logic [2:0] ch, input logic [3:0] dv, input logic ex,
      input logic bn, input logic lf, input logic al, input logic di, input logic [2:0] pk);
    return {pk, di, al, lf, bn, ex, dv, ch, 1'b1};
  endfunction
  function automatic logic [31:0] bw(input logic [7:0] a, input logic [11:0] c, input logic xf,
      input logic dc, input logic ss, input logic sc);
    return {c, sc, ss, dc, xf, 8'h00, a};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 256; a++)
      for (int h = 0; h < 2; h++) begin
        bmem[a][h] = 16'h5A00 + 16'(a * 3 + h * 7);
        bx[a][h] = a[0] ^ h[0];
      end
    rst_n = 0; cmd_valid = 0; ctl_valid = 0; dev_stb = 0; dev_end = 0;
    dev_in_exec = 0; cmd_word = 0; dev_in_data = 0; ctl_word = 0;
    repeat (3) tick();
    // R13 reset state
    chk("R13 busy", busy, 0); chk("R13 connected", connected, 0);
    chk("R13 active", active, 0); chk("R13 remain", remain_cnt, 0);
    rst_n = 1;
    repeat (4) tick();

    // R2 ignored link orders
    cmd(lnk(3'd5, 4'd2, 1, 1, 1, 1, 1, 3'd4));
    chk("R2 other channel", busy, 0);
    cmd(lnk(3'd3, 4'd2, 1, 1, 1, 1, 1, 3'd4) & 16'hFFFE);
    chk("R2 bit0 clear", busy, 0);

    // R1 link, device to memory, alternating from left
    cmd(lnk(3'd3, 4'd5, 1, 1, 1, 1, 1, 3'd4));
    chk("R1 settling", busy, 1);
    blk(bw(8'h10, 12'd3, 1, 0, 0, 1));
    chk("R3 reject while busy", ctl_reject, 1);
    repeat (4) tick();
    chk("R1 linked", connected, 1); chk("R1 device code", cfg_dev, 5);

    blk(bw(8'h10, 12'd3, 1, 0, 0, 1));
    blk(bw(8'h80, 12'd9, 1, 0, 0, 1));
    chk("R3 reject while active", ctl_reject, 1);
    run(12);
    tick();
    chk("R8 count exhausted", remain_cnt, 0);
    chk("R7 address after three words", mem_addr, 8'h13);
    chk("R4 last word written", bmem[8'h12][1], 16'hA000 + 16'(7 * 17));

    // R5 memory to device, fixed right half, end on signal, disconnect
    cmd(lnk(3'd3, 4'd6, 0, 0, 0, 0, 0, 3'd1));
    repeat (5) tick();
    blk(bw(8'h20, 12'd10, 1, 1, 1, 0));
    dev_stb = 1; repeat (5) tick();
    dev_end = 1; tick(); dev_end = 0; dev_stb = 0;
    chk("R9 remain after signal", remain_cnt, 4);
    chk("R11 dropped at end", connected, 0);
    chk("R10 completion pulse", irq_done, 1);
    tick();

    // R6 skip mode
    cmd(lnk(3'd3, 4'd7, 1, 0, 1, 0, 1, 3'd2));
    repeat (5) tick();
    blk(bw(8'h30, 12'd2, 0, 0, 0, 1));
    run(5); tick();
    chk("R6 skip advanced", mem_addr, 8'h32);
    chk("R6 skip memory untouched", bmem[8'h30][0], 16'h5A00 + 16'(8'h30 * 3));

    // R8 zero count
    blk(bw(8'h40, 12'd0, 1, 0, 0, 1));
    tick();
    chk("R8 zero count ends", irq_done, 1);
    chk("R8 zero count no step", mem_addr, 8'h40);

    // R9 both stops, signal first
    blk(bw(8'h50, 12'd5, 1, 0, 1, 1));
    dev_stb = 1; repeat (2) tick(); dev_stb = 0; dev_end = 1; tick(); dev_end = 0;
    chk("R9 first condition wins", remain_cnt, 3);
    tick();

    // R12 enables and clear
    cmd(16'h5000 | 16'h0006);
    chk("R12 ready interrupt", irq_rdy, 1);
    dev_end = 1; #1; chk("R12 signal interrupt", irq_sig, 1); dev_end = 0;
    blk(bw(8'h60, 12'd7, 1, 0, 0, 0));
    run(3);
    cmd(16'h0007);
    chk("R12 clear aborts", active, 0);
    chk("R12 clear unlinks", connected, 0);
    tick();
    chk("R12 no completion on abort", irq_done, 0);
    repeat (3) tick();
    finish_run();
  end
endmodule